// File: doc/BRIEF.md
# DRAM bank timing scheduler

This block decides, cycle by cycle, which command a small multi-bank DRAM channel receives. Each bank presents at most one pending request carrying a row address and a read/write flag. The scheduler keeps, for every bank, whether a row is open, which row that is, and a set of countdown timers. It also keeps a few channel-wide timers that space out column commands and bus turnarounds. From this state it emits one command per cycle, or a no-op, together with the target bank and row.

The requester sees a command on the outputs during the cycle in which it is issued. It is expected to retire a read or write request once the matching column command appears. Activate and precharge commands do not retire a request; they only prepare the bank for it. All timing values are elaboration-time parameters. The two write turnarounds are computed from write latency, half the burst length and a separate recovery value. The read-to-write turnaround and the activate-to-write delay are computed from the latencies as well.

Top module: `dram_bank_sched`

## Requirements
- R1: While `rst` is high, `cmd_kind` is 0 (no-op). After reset every bank is idle, every timer is clear, and the round-robin scan begins at bank 0.
- R2: Command codes on `cmd_kind` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge. At most one command is issued per cycle across all banks. A command is issued only for a bank with a pending request.
- R3: An activate goes to an idle bank with a pending request once that bank's precharge timer and row-cycle timer (34) have expired and the channel activate-to-activate timer (8) has expired. `cmd_row` carries the requested row, and that row becomes the bank's open row.
- R4: A read goes to a bank whose open row equals the requested row. It issues no sooner than 12 cycles after that bank's activate, 2 cycles after any column command, and WL + BL/2 + tCDLR = 11 cycles after any write.
- R5: A write goes to a bank whose open row equals the requested row. It issues no sooner than tRCD − (WL + 1) = 7 cycles after that bank's activate, 2 cycles after any column command, and CL + BL/2 + 2 − WL = 9 cycles after any read.
- R6: On a row miss, a precharge issues no sooner than 21 cycles after that bank's activate and WL + BL/2 + tWR = 19 cycles after that bank's last write. `cmd_row` carries the row being closed. The bank then becomes idle, and its next activate waits 13 cycles.
- R7: When a read or write is eligible in some bank, it is issued ahead of any eligible activate or precharge in the same cycle.
- R8: Within each class (column, row), banks are scanned in circular order starting just after the bank that last issued a command.
- R9: A spacing of N cycles means the later command can issue exactly N cycles after the earlier one when nothing else blocks it. Timers count down to zero and stay there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_BANKS | Pending request present, one bit per bank |
| req_write | input | NUM_BANKS | Request is a write (1) or read (0), one bit per bank |
| req_row | input | NUM_BANKS*ROW_W | Requested row per bank, bank b at bits [b*ROW_W +: ROW_W] |
| cmd_kind | output | 3 | Command issued this cycle (encoding in R2) |
| cmd_bank | output | BANK_IDX_W | Target bank of the command |
| cmd_row | output | ROW_W | Row opened, accessed or closed by the command |

## Verification
A column command in one bank and a precharge in another can become eligible in the same cycle. The bench sets this up on purpose. Bank 0 reads and then needs a different row, so its activate-to-precharge window ends at cycle 21. Bank 1 writes to an open row, and its read-to-write turnaround also ends at cycle 21. The expected outcome is the write in cycle 21 and the precharge one cycle later. A second scenario lines up two banks that are both ready to read, and checks that the grant alternates after the bank that issued last.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } dram_cmd_e;

    typedef enum logic {
        BK_IDLE = 1'b0,
        BK_OPEN = 1'b1
    } bank_st_e;

    // Write data end to read command turnaround
    function automatic int unsigned wr_to_rd(int unsigned wl, int unsigned bl, int unsigned cdlr);
        return wl + bl / 2 + cdlr;
    endfunction

    // Write data end to precharge in the same bank
    function automatic int unsigned wr_to_pre(int unsigned wl, int unsigned bl, int unsigned wr);
        return wl + bl / 2 + wr;
    endfunction

    // Read to write bus turnaround
    function automatic int unsigned rd_to_wr(int unsigned cl, int unsigned bl, int unsigned wl);
        return (cl + bl / 2 + 2 > wl) ? cl + bl / 2 + 2 - wl : 0;
    endfunction

    // Activate to write, shortened by the write latency
    function automatic int unsigned act_to_wr(int unsigned rcd, int unsigned wl);
        return (rcd > wl + 1) ? rcd - (wl + 1) : 0;
    endfunction

    // A gap of N cycles is held by loading N-1 on issue
    function automatic int unsigned reload(int unsigned gap);
        return (gap == 0) ? 0 : gap - 1;
    endfunction

endpackage

// File: rtl/dram_bank_ctx.sv
module dram_bank_ctx
    import dram_sched_pkg::*;
#(
    parameter int unsigned ROW_W   = 12,
    parameter int unsigned TMR_W   = 8,
    parameter int unsigned T_RCD   = 12,
    parameter int unsigned T_RCDWR = 7,
    parameter int unsigned T_RAS   = 21,
    parameter int unsigned T_RP    = 13,
    parameter int unsigned T_RC    = 34,
    parameter int unsigned T_WTP   = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic             rd_ok,
    input  logic             wr_ok,
    input  logic             act_ok,
    input  logic             do_act,
    input  logic             do_rd,
    input  logic             do_wr,
    input  logic             do_pre,
    output logic             col_req,
    output logic             col_wr,
    output logic             row_req,
    output logic             row_act,
    output logic [ROW_W-1:0] open_row
);

    localparam logic [TMR_W-1:0] LD_RCD   = TMR_W'(reload(T_RCD));
    localparam logic [TMR_W-1:0] LD_RCDWR = TMR_W'(reload(T_RCDWR));
    localparam logic [TMR_W-1:0] LD_RAS   = TMR_W'(reload(T_RAS));
    localparam logic [TMR_W-1:0] LD_RP    = TMR_W'(reload(T_RP));
    localparam logic [TMR_W-1:0] LD_RC    = TMR_W'(reload(T_RC));
    localparam logic [TMR_W-1:0] LD_WTP   = TMR_W'(reload(T_WTP));

    bank_st_e         st_q;
    logic [ROW_W-1:0] row_q;
    logic [TMR_W-1:0] rcd_q, rcdwr_q, ras_q, rp_q, rc_q, wtp_q;
    logic             hit, act_go, pre_go;

    function automatic logic [TMR_W-1:0] tick(input logic [TMR_W-1:0] v);
        return (v != '0) ? v - 1'b1 : v;
    endfunction

    always_comb begin
        hit     = (st_q == BK_OPEN) && (row_q == req_row);
        col_req = req_valid && hit &&
                  (req_write ? (rcdwr_q == '0 && wr_ok) : (rcd_q == '0 && rd_ok));
        col_wr  = req_write;
        act_go  = req_valid && (st_q == BK_IDLE) && (rp_q == '0) && (rc_q == '0) && act_ok;
        pre_go  = req_valid && (st_q == BK_OPEN) && (row_q != req_row) &&
                  (ras_q == '0) && (wtp_q == '0);
        row_req = act_go || pre_go;
        row_act = act_go;
    end

    assign open_row = row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= BK_IDLE;
            row_q   <= '0;
            rcd_q   <= '0;
            rcdwr_q <= '0;
            ras_q   <= '0;
            rp_q    <= '0;
            rc_q    <= '0;
            wtp_q   <= '0;
        end else begin
            rcd_q   <= do_act ? LD_RCD   : tick(rcd_q);
            rcdwr_q <= do_act ? LD_RCDWR : tick(rcdwr_q);
            ras_q   <= do_act ? LD_RAS   : tick(ras_q);
            rc_q    <= do_act ? LD_RC    : tick(rc_q);
            rp_q    <= do_pre ? LD_RP    : tick(rp_q);
            wtp_q   <= do_wr  ? LD_WTP   : tick(wtp_q);
            if (do_act) begin
                st_q  <= BK_OPEN;
                row_q <= req_row;
            end else if (do_pre) begin
                st_q  <= BK_IDLE;
            end
        end
    end

    assert_act_idle_R3: assert property (@(posedge clk) disable iff (rst)
        do_act |-> (st_q == BK_IDLE && rp_q == '0 && rc_q == '0));

    assert_col_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (do_rd || do_wr) |-> (st_q == BK_OPEN && row_q == req_row));

    assert_pre_timers_R6: assert property (@(posedge clk) disable iff (rst)
        do_pre |-> (st_q == BK_OPEN && ras_q == '0 && wtp_q == '0));

    assert_pre_closes_R6: assert property (@(posedge clk) disable iff (rst)
        do_pre |=> (st_q == BK_IDLE));

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (rst)
        do_act |=> (st_q == BK_OPEN && row_q == $past(req_row)));

endmodule

// File: rtl/dram_chan_timers.sv
module dram_chan_timers
    import dram_sched_pkg::*;
#(
    parameter int unsigned TMR_W = 8,
    parameter int unsigned T_CCD = 2,
    parameter int unsigned T_RRD = 8,
    parameter int unsigned T_WTR = 11,
    parameter int unsigned T_RTW = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic any_act,
    input  logic any_rd,
    input  logic any_wr,
    output logic rd_ok,
    output logic wr_ok,
    output logic act_ok
);

    localparam logic [TMR_W-1:0] LD_CCD = TMR_W'(reload(T_CCD));
    localparam logic [TMR_W-1:0] LD_RRD = TMR_W'(reload(T_RRD));
    localparam logic [TMR_W-1:0] LD_WTR = TMR_W'(reload(T_WTR));
    localparam logic [TMR_W-1:0] LD_RTW = TMR_W'(reload(T_RTW));

    logic [TMR_W-1:0] ccd_q, rrd_q, wtr_q, rtw_q;

    function automatic logic [TMR_W-1:0] tick(input logic [TMR_W-1:0] v);
        return (v != '0) ? v - 1'b1 : v;
    endfunction

    assign rd_ok  = (ccd_q == '0) && (wtr_q == '0);
    assign wr_ok  = (ccd_q == '0) && (rtw_q == '0);
    assign act_ok = (rrd_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ccd_q <= '0;
            rrd_q <= '0;
            wtr_q <= '0;
            rtw_q <= '0;
        end else begin
            ccd_q <= (any_rd || any_wr) ? LD_CCD : tick(ccd_q);
            rrd_q <= any_act ? LD_RRD : tick(rrd_q);
            wtr_q <= any_wr  ? LD_WTR : tick(wtr_q);
            rtw_q <= any_rd  ? LD_RTW : tick(rtw_q);
        end
    end

    assert_rd_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        any_rd |-> (wtr_q == '0 && ccd_q == '0));

    assert_wr_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        any_wr |-> (rtw_q == '0 && ccd_q == '0));

    assert_act_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        any_act |-> (rrd_q == '0));

    assert_one_column_R2: assert property (@(posedge clk) disable iff (rst)
        !(any_rd && any_wr));

endmodule

// File: rtl/dram_rr_pick.sv
module dram_rr_pick #(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             found,
    output logic [IDX_W-1:0] pick
);

    int cand;

    always_comb begin
        found = 1'b0;
        pick  = last;
        cand  = 0;
        for (int off = 1; off <= int'(N); off++) begin
            cand = int'(last) + off;
            if (cand >= int'(N)) cand = cand - int'(N);
            if (!found && req[IDX_W'(cand)]) begin
                found = 1'b1;
                pick  = IDX_W'(cand);
            end
        end
    end

endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched
    import dram_sched_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned ROW_W     = 12,
    parameter int unsigned TMR_W     = 8,
    parameter int unsigned T_CCD     = 2,
    parameter int unsigned T_RRD     = 8,
    parameter int unsigned T_RCD     = 12,
    parameter int unsigned T_RAS     = 21,
    parameter int unsigned T_RP      = 13,
    parameter int unsigned T_RC      = 34,
    parameter int unsigned T_CL      = 9,
    parameter int unsigned T_WL      = 4,
    parameter int unsigned T_CDLR    = 5,
    parameter int unsigned T_WR      = 13,
    parameter int unsigned BURST_LEN = 4,
    localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_BANKS-1:0]       req_valid,
    input  logic [NUM_BANKS-1:0]       req_write,
    input  logic [NUM_BANKS*ROW_W-1:0] req_row,
    output logic [2:0]                 cmd_kind,
    output logic [BANK_IDX_W-1:0]      cmd_bank,
    output logic [ROW_W-1:0]           cmd_row
);

    localparam int unsigned T_WTR   = wr_to_rd(T_WL, BURST_LEN, T_CDLR);
    localparam int unsigned T_WTP   = wr_to_pre(T_WL, BURST_LEN, T_WR);
    localparam int unsigned T_RTW   = rd_to_wr(T_CL, BURST_LEN, T_WL);
    localparam int unsigned T_RCDWR = act_to_wr(T_RCD, T_WL);

    logic [NUM_BANKS-1:0]  col_req, col_wr, row_req, row_act;
    logic [NUM_BANKS-1:0]  do_act, do_rd, do_wr, do_pre;
    logic [ROW_W-1:0]      open_row [NUM_BANKS];
    logic                  rd_ok, wr_ok, act_ok;
    logic                  col_found, row_found;
    logic [BANK_IDX_W-1:0] col_pick, row_pick, sel_c, last_q;
    dram_cmd_e             kind_c;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign do_act[b] = (kind_c == CMD_ACT) && (sel_c == BANK_IDX_W'(b));
            assign do_rd[b]  = (kind_c == CMD_RD)  && (sel_c == BANK_IDX_W'(b));
            assign do_wr[b]  = (kind_c == CMD_WR)  && (sel_c == BANK_IDX_W'(b));
            assign do_pre[b] = (kind_c == CMD_PRE) && (sel_c == BANK_IDX_W'(b));

            dram_bank_ctx #(
                .ROW_W(ROW_W), .TMR_W(TMR_W), .T_RCD(T_RCD), .T_RCDWR(T_RCDWR),
                .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC), .T_WTP(T_WTP)
            ) u_bank (
                .clk(clk), .rst(rst),
                .req_valid(req_valid[b]), .req_write(req_write[b]),
                .req_row(req_row[b*ROW_W +: ROW_W]),
                .rd_ok(rd_ok), .wr_ok(wr_ok), .act_ok(act_ok),
                .do_act(do_act[b]), .do_rd(do_rd[b]), .do_wr(do_wr[b]), .do_pre(do_pre[b]),
                .col_req(col_req[b]), .col_wr(col_wr[b]),
                .row_req(row_req[b]), .row_act(row_act[b]),
                .open_row(open_row[b])
            );
        end
    endgenerate

    dram_chan_timers #(
        .TMR_W(TMR_W), .T_CCD(T_CCD), .T_RRD(T_RRD), .T_WTR(T_WTR), .T_RTW(T_RTW)
    ) u_chan (
        .clk(clk), .rst(rst),
        .any_act(|do_act), .any_rd(|do_rd), .any_wr(|do_wr),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .act_ok(act_ok)
    );

    dram_rr_pick #(.N(NUM_BANKS), .IDX_W(BANK_IDX_W)) u_col_pick (
        .req(col_req), .last(last_q), .found(col_found), .pick(col_pick)
    );

    dram_rr_pick #(.N(NUM_BANKS), .IDX_W(BANK_IDX_W)) u_row_pick (
        .req(row_req), .last(last_q), .found(row_found), .pick(row_pick)
    );

    always_comb begin
        kind_c = CMD_NOP;
        sel_c  = '0;
        if (!rst) begin
            if (col_found) begin
                sel_c  = col_pick;
                kind_c = col_wr[col_pick] ? CMD_WR : CMD_RD;
            end else if (row_found) begin
                sel_c  = row_pick;
                kind_c = row_act[row_pick] ? CMD_ACT : CMD_PRE;
            end
        end
    end

    assign cmd_kind = kind_c;
    assign cmd_bank = sel_c;
    assign cmd_row  = (kind_c == CMD_PRE) ? open_row[sel_c] : req_row[sel_c*ROW_W +: ROW_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= BANK_IDX_W'(NUM_BANKS - 1);
        end else if (kind_c != CMD_NOP) begin
            last_q <= sel_c;
        end
    end

    assert_single_issue_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(do_act | do_rd | do_wr | do_pre));

    assert_issue_has_req_R2: assert property (@(posedge clk) disable iff (rst)
        ((do_act | do_rd | do_wr | do_pre) & ~req_valid) == '0);

    assert_column_first_R7: assert property (@(posedge clk) disable iff (rst)
        ((|do_act) || (|do_pre)) |-> (col_req == '0));

endmodule

// File: tb/dram_bank_sched_tb.sv
module dram_bank_sched_tb_top;

    localparam int NB    = 4;
    localparam int RW    = 12;
    localparam int IW    = 2;
    localparam int RUN   = 64;
    localparam int REQ_N = 13;
    localparam int EV_N  = 22;

    // Request queues: scenario, bank, write flag, row (served in order per bank)
    localparam int REQ_SCN  [REQ_N] = '{0,0,0, 1,1,1, 2,2,2,2,2,2,2};
    localparam int REQ_BANK [REQ_N] = '{0,0,0, 0,0,1, 0,0,0,0,0,1,1};
    localparam int REQ_WR   [REQ_N] = '{1,0,1, 0,0,1, 0,0,0,0,0,0,0};
    localparam int REQ_ROW  [REQ_N] = '{5,5,9, 1,3,2, 1,1,1,1,1,2,2};

    // Expected issue trace: scenario, command code, bank, row, cycle
    // S0 (R3,R5,R4,R6,R9): act c0, write c7, read c18 (write-to-read 11),
    //    precharge c26 (write-to-precharge 19 beats tRAS 21), act c39, write c46
    // S1 (R7): write b1 and precharge b0 both eligible at c21; write wins
    // S2 (R8): both banks read-ready at c20 and c22; scan alternates
    localparam int EV_SCN  [EV_N] = '{0,0,0,0,0,0, 1,1,1,1,1,1,1, 2,2,2,2,2,2,2,2,2};
    localparam int EV_CMD  [EV_N] = '{1,3,2,4,1,3, 1,1,2,3,4,1,2, 1,1,2,2,2,2,2,2,2};
    localparam int EV_BANK [EV_N] = '{0,0,0,0,0,0, 0,1,0,1,0,0,0, 0,1,0,0,0,0,1,0,1};
    localparam int EV_ROW  [EV_N] = '{5,5,5,5,9,9, 1,2,1,2,1,3,3, 1,2,1,1,1,1,2,1,2};
    localparam int EV_CYC  [EV_N] = '{0,7,18,26,39,46, 0,8,12,21,22,35,47,
                                      0,8,12,14,16,18,20,22,24};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NB-1:0]     req_valid = '0;
    logic [NB-1:0]     req_write = '0;
    logic [NB*RW-1:0]  req_row = '0;
    logic [2:0]        cmd_kind;
    logic [IW-1:0]     cmd_bank;
    logic [RW-1:0]     cmd_row;

    int n_checks = 0;
    int n_fails  = 0;
    int ptr [NB];

    always #4 clk = ~clk;

    dram_bank_sched dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_row(cmd_row)
    );

    function automatic string tag_of(int s, int ev);
        if (s == 1 && EV_CYC[ev] >= 21 && EV_CYC[ev] <= 22) return "R7";
        if (s == 2 && EV_CYC[ev] >= 20) return "R8";
        case (EV_CMD[ev])
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic int find_req(int s, int b, int from);
        for (int i = from; i < REQ_N; i++)
            if (REQ_SCN[i] == s && REQ_BANK[i] == b) return i;
        return -1;
    endfunction

    task automatic drive_reqs();
        for (int b = 0; b < NB; b++) begin
            if (ptr[b] >= 0) begin
                req_valid[b]           = 1'b1;
                req_write[b]           = REQ_WR[ptr[b]] != 0;
                req_row[b*RW +: RW]    = RW'(REQ_ROW[ptr[b]]);
            end else begin
                req_valid[b]           = 1'b0;
                req_write[b]           = 1'b0;
                req_row[b*RW +: RW]    = '0;
            end
        end
    endtask

    task automatic run_scenario(int s);
        int ep;
        ep = 0;
        while (ep < EV_N && EV_SCN[ep] != s) ep++;
        for (int b = 0; b < NB; b++) ptr[b] = find_req(s, b, 0);
        rst = 1'b1;
        drive_reqs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (s == 0) begin
            // R1: requests pending while reset is held must not produce a command
            n_checks++;
            if (cmd_kind !== 3'd0) begin
                n_fails++;
                $display("FAIL R1 reset: cmd_kind=%0d expected 0", cmd_kind);
            end
        end
        rst = 1'b0;
        for (int cyc = 0; cyc < RUN; cyc++) begin
            if (cyc > 0) @(negedge clk);
            drive_reqs();
            #1;
            if (cmd_kind != 3'd0) begin
                n_checks++;
                if (ep >= EV_N || EV_SCN[ep] != s) begin
                    n_fails++;
                    $display("FAIL R2 s%0d c%0d: unexpected cmd=%0d bank=%0d row=%0d expected none",
                             s, cyc, cmd_kind, cmd_bank, cmd_row);
                end else begin
                    if (int'(cmd_kind) != EV_CMD[ep] || int'(cmd_bank) != EV_BANK[ep] ||
                        int'(cmd_row) != EV_ROW[ep] || cyc != EV_CYC[ep]) begin
                        n_fails++;
                        $display("FAIL %s s%0d: got cmd=%0d bank=%0d row=%0d cycle=%0d expected cmd=%0d bank=%0d row=%0d cycle=%0d",
                                 tag_of(s, ep), s, cmd_kind, cmd_bank, cmd_row, cyc,
                                 EV_CMD[ep], EV_BANK[ep], EV_ROW[ep], EV_CYC[ep]);
                    end
                    ep++;
                end
                if (cmd_kind == 3'd2 || cmd_kind == 3'd3) begin
                    if (ptr[cmd_bank] >= 0)
                        ptr[cmd_bank] = find_req(s, int'(cmd_bank), ptr[cmd_bank] + 1);
                end
            end
            @(posedge clk);
        end
        // R9: every expected command of the scenario appeared
        n_checks++;
        if (ep < EV_N && EV_SCN[ep] == s) begin
            n_fails++;
            $display("FAIL R9 s%0d: trace ended at event %0d, expected cmd=%0d at cycle %0d",
                     s, ep, EV_CMD[ep], EV_CYC[ep]);
        end
    endtask

    initial begin
        for (int s = 0; s < 3; s++) run_scenario(s);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule